// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block keeps a 64-bit running sum, stored as a high word and a low word, and changes it with one of three operations. Each operation is presented with a valid strobe and finishes in one clock cycle. The accumulate operation multiplies two signed 32-bit operands, keeps only the low 32 bits of the product as a signed value, sign-extends that value to 64 bits, and adds it to the sum. The subtract operation forms the product in the same way and subtracts it. The read operation returns the current low word on the read-data output and zeroes the whole sum in the same cycle.

Both halves of the sum are visible at all times on direct output ports, so a surrounding datapath can sample them without issuing a read. Arithmetic on the sum wraps modulo 2^64, and no overflow indication is produced. A synchronous active-high reset clears the sum and the read-data register.

Top module: `mac_accum_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_hi`, `acc_lo` and `rd_data` become zero after that edge.
- R2: With `in_valid` high and `in_op` = 2'b00 (accumulate), the 64-bit value {acc_hi, acc_lo} after the edge equals the value before it plus the sign-extended low 32 bits of `in_x` * `in_y`.
- R3: With `in_valid` high and `in_op` = 2'b01 (subtract), the 64-bit value after the edge equals the value before it minus the same sign-extended truncated product.
- R4: With `in_valid` high and `in_op` = 2'b10 (read and clear), `rd_data` after the edge holds `acc_lo` as it was before the edge, and both `acc_hi` and `acc_lo` are zero after the edge.
- R5: `rd_data` changes only on a read-and-clear or a reset and otherwise keeps its value.
- R6: When `in_valid` is low, or `in_op` = 2'b11, the sum is unchanged whatever `in_x` and `in_y` carry.
- R7: Sum arithmetic wraps modulo 2^64: carries pass from the low word into the high word, and a result past either end of the 64-bit range wraps with no flag.
- R8: Product bits above bit 31 are discarded before the sum is updated, so a product of 2^32 adds nothing and a product of 2^31 adds the negative value -2^31.
- R9: An operation issued in the cycle right after another sees the sum as that earlier operation left it, so a read-and-clear right after an accumulate returns the updated low word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe; an operation takes effect only when high |
| in_op | input | 2 | Operation select: 00 accumulate, 01 subtract, 10 read and clear, 11 no operation |
| in_x | input | 32 | First signed multiplicand |
| in_y | input | 32 | Second signed multiplicand |
| rd_data | output | 32 | Low word captured by the most recent read-and-clear |
| acc_hi | output | 32 | Upper half of the 64-bit sum |
| acc_lo | output | 32 | Lower half of the 64-bit sum |

## Verification
The bench targets product truncation. Operand pairs whose full product is exactly 2^32 or 2^31 separate a design that keeps the full 64-bit product, which would add 2^32, from one that zero-extends the truncated product, which would leave the high word at zero instead of all ones. Carry and borrow across the 32-bit boundary, and wrap past zero in both directions, show whether the two halves are joined into one 64-bit adder or kept as two separate 32-bit words. Back-to-back read-after-accumulate sequences, and strobes with valid low or the unused op code, catch a read that returns a stale word, a clear that misses a half, and updates made while the unit is idle.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_ACC   = 2'b00,
    OP_SUB   = 2'b01,
    OP_RDCLR = 2'b10,
    OP_NONE  = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 2 * DATA_W
) (
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  output logic [ACC_W-1:0]  prod_ext
);
  localparam int EXT_W = ACC_W - DATA_W;

  logic [DATA_W-1:0] prod_trunc;

  // Low DATA_W bits of a two's-complement product do not depend on signedness.
  assign prod_trunc = op_a * op_b;
  assign prod_ext   = {{EXT_W{prod_trunc[DATA_W-1]}}, prod_trunc};
endmodule

// File: rtl/mac_acc_next.sv
module mac_acc_next
  import mac_pkg::*;
#(
  parameter int ACC_W = 64
) (
  input  logic             valid,
  input  mac_op_e          op,
  input  logic [ACC_W-1:0] acc_cur,
  input  logic [ACC_W-1:0] prod_ext,
  output logic [ACC_W-1:0] acc_nxt,
  output logic             rd_load
);
  always_comb begin
    acc_nxt = acc_cur;
    rd_load = 1'b0;
    if (valid) begin
      unique case (op)
        OP_ACC:   acc_nxt = acc_cur + prod_ext;
        OP_SUB:   acc_nxt = acc_cur - prod_ext;
        OP_RDCLR: begin
          acc_nxt = '0;
          rd_load = 1'b1;
        end
        default:  acc_nxt = acc_cur;
      endcase
    end
  end
endmodule

// File: rtl/mac_accum_unit.sv
module mac_accum_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [DATA_W-1:0] in_x,
  input  logic [DATA_W-1:0] in_y,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] acc_lo
);
  localparam int ACC_W = 2 * DATA_W;

  mac_op_e          op_sel;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] prod_ext;
  logic             rd_load;
  logic [DATA_W-1:0] rd_q;

  assign op_sel = mac_op_e'(in_op);

  mac_product #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_product (
    .op_a     (in_x),
    .op_b     (in_y),
    .prod_ext (prod_ext)
  );

  mac_acc_next #(.ACC_W(ACC_W)) u_next (
    .valid    (in_valid),
    .op       (op_sel),
    .acc_cur  (acc_q),
    .prod_ext (prod_ext),
    .acc_nxt  (acc_d),
    .rd_load  (rd_load)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      rd_q  <= '0;
    end else begin
      acc_q <= acc_d;
      if (rd_load) rd_q <= acc_q[DATA_W-1:0];
    end
  end

  assign acc_hi  = acc_q[ACC_W-1:DATA_W];
  assign acc_lo  = acc_q[DATA_W-1:0];
  assign rd_data = rd_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || in_op == 2'b11) |=> $stable({acc_hi, acc_lo})); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b10) |=> (acc_hi == '0 && acc_lo == '0)); // R4

  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b10) |=> rd_data == $past(acc_lo)); // R4

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_op == 2'b10) |=> $stable(rd_data)); // R5

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b00) |=>
      {acc_hi, acc_lo} == $past({acc_hi, acc_lo}) + $past(prod_ext)); // R2

  AST_SUB_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 2'b01) |=>
      {acc_hi, acc_lo} == $past({acc_hi, acc_lo}) - $past(prod_ext)); // R3
endmodule

// File: tb/test_mac_accum_unit.sv
`timescale 1ns/1ps
module test_mac_accum_unit;
  localparam int W = 32;

  typedef struct {
    logic [63:0] acc;
    logic [31:0] rd;
    string       tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    in_op = 2'b11;
  logic [W-1:0]  in_x = '0;
  logic [W-1:0]  in_y = '0;
  logic [W-1:0]  rd_data, acc_hi, acc_lo;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t q[$];
  logic [63:0] m_acc = '0;
  logic [31:0] m_rd = '0;

  always #2.5 clk = ~clk;

  mac_accum_unit #(.DATA_W(W)) i_mac_accum_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_x(in_x), .in_y(in_y), .rd_data(rd_data), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  function automatic logic [63:0] sext_prod(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] full;
    logic [31:0] low;
    full = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    low  = full[31:0];
    return {{32{low[31]}}, low};
  endfunction

  task automatic push(input string tag);
    exp_t e;
    e.acc = m_acc; e.rd = m_rd; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_op(input logic v, input logic [1:0] op,
                       input logic [31:0] x, input logic [31:0] y, input string tag);
    @(negedge clk);
    rst = 1'b0; in_valid = v; in_op = op; in_x = x; in_y = y;
    if (v) begin
      case (op)
        2'b00: m_acc = m_acc + sext_prod(x, y);
        2'b01: m_acc = m_acc - sext_prod(x, y);
        2'b10: begin m_rd = m_acc[31:0]; m_acc = '0; end
        default: ;
      endcase
    end
    push(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_op = 2'b00; in_x = 32'd9; in_y = 32'd9;
    m_acc = '0; m_rd = '0;
    push(tag);
  endtask

  // Monitor: compares each committed cycle with the scoreboard entry.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({acc_hi, acc_lo} !== e.acc || rd_data !== e.rd) begin
        failures++;
        $display("FAIL %s: acc=%h rd=%h expected acc=%h rd=%h",
                 e.tag, {acc_hi, acc_lo}, rd_data, e.acc, e.rd);
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    do_reset("R1 reset state");
    do_reset("R1 reset state");
    do_op(1, 2'b00, 32'd3, 32'd4, "R2 accumulate positive");
    do_op(1, 2'b00, -32'sd5, 32'd7, "R2 accumulate negative");
    do_op(1, 2'b10, 32'h0, 32'h0, "R4 R9 read right after accumulate");
    do_op(1, 2'b10, 32'h0, 32'h0, "R4 read of cleared sum");
    do_op(1, 2'b00, 32'h0001_0000, 32'h0001_0000, "R8 product 2^32 truncates to zero");
    do_op(1, 2'b00, 32'h0001_0000, 32'h0000_8000, "R8 product 2^31 is negative");
    do_op(1, 2'b01, 32'h0001_0000, 32'h0000_8000, "R3 subtract truncated product");
    do_op(1, 2'b01, 32'd1, 32'd1, "R7 wrap below zero");
    do_op(1, 2'b00, 32'd1, 32'd1, "R7 wrap back to zero");
    do_op(1, 2'b00, 32'h7FFF_FFFF, 32'd1, "R7 carry setup");
    do_op(1, 2'b00, 32'h7FFF_FFFF, 32'd1, "R7 carry setup");
    do_op(1, 2'b00, 32'd1, 32'd1, "R7 low word full");
    do_op(1, 2'b00, 32'd1, 32'd1, "R7 carry into high word");
    do_op(1, 2'b01, 32'd1, 32'd1, "R7 borrow from high word");
    do_op(0, 2'b00, 32'h1234_5678, 32'h9ABC_DEF0, "R6 valid low ignored");
    do_op(1, 2'b11, 32'h1234_5678, 32'h9ABC_DEF0, "R6 op 11 ignored");
    do_op(1, 2'b00, 32'h8000_0000, 32'hFFFF_FFFF, "R2 most negative operand");
    do_op(1, 2'b00, 32'd2, 32'd3, "R5 rd holds during accumulate");
    do_op(1, 2'b01, 32'd6, 32'd6, "R3 R9 subtract then read");
    do_op(1, 2'b10, 32'h0, 32'h0, "R4 R9 read after subtract");
    do_op(1, 2'b00, 32'd11, 32'd13, "R5 rd holds after read");
    do_reset("R1 reset mid run");
    lf = 32'hACE1_2345;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      do_op(lf[3] | lf[9], lf[5:4], {lf[15:0], lf[31:16]}, lf ^ 32'h5A5A_00FF,
            "R2 R3 R4 R6 mixed sequence");
    end
    do_op(0, 2'b11, 32'h0, 32'h0, "R6 final idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule